// File: doc/BRIEF.md
# Dual Memory Self-Test Controller

This block checks two on-chip memories that belong to one channel: a coefficient memory and a data memory. Software writes the enable bit of a small status word to start a run. A run is accepted only while the channel is asleep. The controller drives both memory ports through a march sequence and compares every read against the pattern it expects. When the run is over it clears its busy bit and leaves one fail flag for each memory. The host polls the 3-bit status word. There is no interrupt.

Both memories are walked in the same pass with one shared index. The smaller memory sits idle while the index is past its depth. The sequence has three passes. First it writes all zeros with the index rising. Second, at each rising index, it reads back zeros and then writes all ones. Third, with the index falling, it reads back ones. One extra cycle then finishes the last compare. A run takes 4·max(depth)+1 cycles. The default sizes keep that well under the 1600-cycle limit. The memory test only uses the two memory ports, so it can run alongside any signal-path test of the channel.

Top module: `dual_mem_selftest`

## Requirements
- R1: After reset the status word `status` reads 3'b000.
- R2: A cycle with `ctl_we`=1, `ctl_en`=1 and `sleep_i`=1 while idle starts a run. From the next cycle `status[0]` (busy) reads 1 until the run ends.
- R3: Busy stays high for exactly 4·max(CDEPTH,DDEPTH)+1 cycles, which is 1025 with the defaults.
- R4: Every run completes within 1600 clock cycles of the enable.
- R5: With both memories fault-free, a completed run leaves `status[2:1]` = 2'b00.
- R6: A stuck-at fault in the coefficient memory alone leaves `status` = 3'b010 after the run. Bit 1 is the coefficient fail flag.
- R7: A stuck-at fault in the data memory alone leaves `status` = 3'b100 after the run. Bit 2 is the data fail flag.
- R8: Both fail flags are cleared when a run starts, and once set they stay set for the rest of that run.
- R9: An enable write while `sleep_i`=0 is ignored and `status` is unchanged.
- R10: An enable write while busy is ignored. This includes a write in the last busy cycle. The run ends at its original time and no second run follows.
- R11: After a fault-free run every word of both memories holds all ones. The sequence is write zeros ascending, then read zeros and write ones ascending, then read ones descending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Channel is asleep; a run may start |
| ctl_we | input | 1 | Host write strobe to the status word |
| ctl_en | input | 1 | Write data for the enable bit |
| status | output | 3 | {data fail, coefficient fail, busy} |
| cm_addr | output | CAW | Coefficient memory address |
| cm_re | output | 1 | Coefficient memory read enable (data returns next cycle) |
| cm_we | output | 1 | Coefficient memory write enable |
| cm_wdata | output | CW | Coefficient memory write data |
| cm_rdata | input | CW | Coefficient memory read data |
| dm_addr | output | DAW | Data memory address |
| dm_re | output | 1 | Data memory read enable (data returns next cycle) |
| dm_we | output | 1 | Data memory write enable |
| dm_wdata | output | DW | Data memory write data |
| dm_rdata | input | DW | Data memory read data |

## Verification
Two functions can fall on the same clock edge. One is the final compare, which also drops busy. The other is a fresh host enable write. The bench provokes this by writing the enable bit in the last busy cycle and again in the middle of a run. It judges the result by three things: the busy count must still equal the expected run length, busy must then stay low, and the fail flags from the finished run must remain readable.

// File: rtl/dual_mem_selftest.sv
module dual_mem_selftest #(
  parameter int CDEPTH = 128,
  parameter int DDEPTH = 256,
  parameter int CW     = 20,
  parameter int DW     = 16,
  parameter int LIMIT  = 1600,
  localparam int MAXD  = (CDEPTH > DDEPTH) ? CDEPTH : DDEPTH,
  localparam int IW    = $clog2(MAXD),
  localparam int CAW   = $clog2(CDEPTH),
  localparam int DAW   = $clog2(DDEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sleep_i,
  input  logic           ctl_we,
  input  logic           ctl_en,
  output logic [2:0]     status,
  output logic [CAW-1:0] cm_addr,
  output logic           cm_re,
  output logic           cm_we,
  output logic [CW-1:0]  cm_wdata,
  input  logic [CW-1:0]  cm_rdata,
  output logic [DAW-1:0] dm_addr,
  output logic           dm_re,
  output logic           dm_we,
  output logic [DW-1:0]  dm_wdata,
  input  logic [DW-1:0]  dm_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_W0, S_R0, S_W1, S_R1, S_DRAIN} st_t;

  st_t          st;
  logic [IW-1:0] idx;
  logic         chk_v, chk_one, chk_c, chk_d;
  logic         fail_c, fail_d;

  wire busy   = (st != S_IDLE);
  wire start  = ctl_we && ctl_en && sleep_i && !busy;
  wire at_top = (idx == IW'(MAXD - 1));
  wire at_bot = (idx == '0);
  wire c_act  = ({1'b0, idx} < (IW + 1)'(CDEPTH));
  wire d_act  = ({1'b0, idx} < (IW + 1)'(DDEPTH));
  wire wr_ph  = (st == S_W0) || (st == S_W1);
  wire rd_ph  = (st == S_R0) || (st == S_R1);

  assign cm_addr  = CAW'(idx);
  assign dm_addr  = DAW'(idx);
  assign cm_we    = c_act && wr_ph;
  assign dm_we    = d_act && wr_ph;
  assign cm_re    = c_act && rd_ph;
  assign dm_re    = d_act && rd_ph;
  assign cm_wdata = {CW{st == S_W1}};
  assign dm_wdata = {DW{st == S_W1}};
  assign status   = {fail_d, fail_c, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
    end else begin
      case (st)
        S_IDLE:  if (start) begin st <= S_W0; idx <= '0; end
        S_W0:    if (at_top) begin st <= S_R0; idx <= '0; end
                 else idx <= idx + 1'b1;
        S_R0:    st <= S_W1;
        S_W1:    if (at_top) st <= S_R1;
                 else begin st <= S_R0; idx <= idx + 1'b1; end
        S_R1:    if (at_bot) st <= S_DRAIN;
                 else idx <= idx - 1'b1;
        S_DRAIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_v   <= 1'b0;
      chk_one <= 1'b0;
      chk_c   <= 1'b0;
      chk_d   <= 1'b0;
    end else begin
      chk_v   <= rd_ph;
      chk_one <= (st == S_R1);
      chk_c   <= c_act;
      chk_d   <= d_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_c <= 1'b0;
      fail_d <= 1'b0;
    end else if (start) begin
      fail_c <= 1'b0;
      fail_d <= 1'b0;
    end else if (chk_v) begin
      if (chk_c && cm_rdata != {CW{chk_one}}) fail_c <= 1'b1;
      if (chk_d && dm_rdata != {DW{chk_one}}) fail_d <= 1'b1;
    end
  end

  logic [11:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_cnt <= '0;
    else if (start)   run_cnt <= '0;
    else if (busy && run_cnt != '1) run_cnt <= run_cnt + 1'b1;
  end

  assert_time_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (run_cnt < 12'(LIMIT)));

  assert_asleep_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[0] && !sleep_i) |=> $stable(status));

  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> (status[2:1] == 2'b00));

  assert_coef_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && status[1]) |=> status[1]);

  assert_data_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && status[2]) |=> status[2]);

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |=> !status[0]);

endmodule

// File: tb/sim_dual_mem_selftest.sv
module sim_dual_mem_selftest;
  localparam int CDEPTH = 128, DDEPTH = 256, CW = 20, DW = 16;
  localparam int MAXD = 256, RUNLEN = 4 * MAXD + 1;

  logic clk = 0, rst_n = 0, sleep_i = 0, ctl_we = 0, ctl_en = 0;
  logic [2:0] status;
  logic [6:0] cm_addr;
  logic [7:0] dm_addr;
  logic cm_re, cm_we, dm_re, dm_we;
  logic [CW-1:0] cm_wdata, cm_rdata, cmem [CDEPTH];
  logic [DW-1:0] dm_wdata, dm_rdata, dmem [DDEPTH];
  logic [CW-1:0] c_and = '1, c_or = '0;
  logic [DW-1:0] d_and = '1, d_or = '0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dual_mem_selftest #(.CDEPTH(CDEPTH), .DDEPTH(DDEPTH), .CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ctl_we(ctl_we), .ctl_en(ctl_en),
    .status(status),
    .cm_addr(cm_addr), .cm_re(cm_re), .cm_we(cm_we), .cm_wdata(cm_wdata), .cm_rdata(cm_rdata),
    .dm_addr(dm_addr), .dm_re(dm_re), .dm_we(dm_we), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata));

  always_ff @(posedge clk) begin
    if (cm_we) cmem[cm_addr] <= (cm_wdata & c_and) | c_or;
    if (cm_re) cm_rdata <= cmem[cm_addr];
    if (dm_we) dmem[dm_addr] <= (dm_wdata & d_and) | d_or;
    if (dm_re) dm_rdata <= dmem[dm_addr];
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic poke(input logic slp);
    @(negedge clk); sleep_i = slp; ctl_we = 1; ctl_en = 1;
    @(negedge clk); ctl_we = 0; ctl_en = 0;
  endtask

  task automatic run(input logic [1:0] exp_flags, input bit late_write);
    int cnt = 0;
    @(negedge clk); sleep_i = 1; ctl_we = 1; ctl_en = 1;
    @(posedge clk);
    @(negedge clk); ctl_we = 0; ctl_en = 0;
    check("R2 busy after enable", status[0], 1);
    check("R8 flags cleared at start", status[2:1], 0);
    while (status[0] && cnt < 3000) begin
      ctl_we = late_write && (cnt == 100 || cnt == RUNLEN - 1);
      ctl_en = ctl_we;
      @(posedge clk); @(negedge clk); cnt++;
    end
    ctl_we = 0; ctl_en = 0;
    check("R3 busy length", cnt, RUNLEN);
    check("R4 within 1600 cycles", int'(cnt < 1600), 1);
    check("R5/R6/R7 fail flags", status[2:1], exp_flags);
    if (late_write) begin
      repeat (3) @(negedge clk);
      check("R10 no restart after late write", status, {exp_flags, 1'b0});
    end
  endtask

  task automatic t_reset;
    check("R1 reset status", status, 0);
  endtask

  task automatic t_clean;
    int bad = 0;
    run(2'b00, 0);
    for (int i = 0; i < CDEPTH; i++) if (cmem[i] != '1) bad++;
    for (int i = 0; i < DDEPTH; i++) if (dmem[i] != '1) bad++;
    check("R11 memories end all ones", bad, 0);
  endtask

  task automatic t_coef_fault;
    c_and = ~(CW'(1) << 3);
    run(2'b01, 0);
    check("R6 status coef only", status, 3'b010);
    c_and = '1;
  endtask

  task automatic t_data_fault;
    d_or = DW'(1) << 5;
    run(2'b10, 0);
    check("R7 status data only", status, 3'b100);
    d_or = '0;
  endtask

  task automatic t_awake;
    poke(0);
    check("R9 awake write ignored", status, 3'b100);
    repeat (4) @(negedge clk);
    check("R9 still idle", status, 3'b100);
  endtask

  task automatic t_rerun_busy_write;
    run(2'b00, 1);
    check("R8 flags clear after clean rerun", status, 3'b000);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_coef_fault();
    t_data_fault();
    t_awake();
    t_rerun_busy_write();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule